// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block takes a stereo PCM stream from a three-wire serial audio link (bit clock, frame clock and data) and turns it into parallel signed samples. All three link wires are brought into the system clock domain and re-timed. Every rising bit-clock edge is then treated as one bit slot. A two-bit format select picks one of four framings at run time: I2S, left-justified, right-justified with a full word, and right-justified with a short word. The two justified-left framings place the sample at the start of each frame-clock half-period. The two right-justified framings place it at the end.

The number of bit-clock cycles in each frame-clock half-period is not fixed and may change from frame to frame. For the right-justified framings, the block keeps a running history of the most recent bits and reads the word out at the moment the frame clock toggles. The samples come out 24 bits wide, MSB aligned. When a right channel has completed and its left partner has already arrived, both samples are presented together with a single-cycle valid strobe.

The format select is expected to change only while reset is asserted.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and directly after it is released, `left_smp` and `right_smp` read zero and `smp_valid` is low.
- R2: With `fmt_sel` = 2'b00 (I2S), `lrck` low marks the left channel, and the MSB is carried by the second `sclk` rising edge after an `lrck` transition. The following bits come in descending order, one per rising edge.
- R3: With `fmt_sel` = 2'b01 (left-justified), `lrck` high marks the left channel, and the MSB is carried by the first `sclk` rising edge after an `lrck` transition.
- R4: With `fmt_sel` = 2'b10 (right-justified, full word), `lrck` high marks the left channel. The sample is the last 24 bits before the `lrck` transition, MSB first, with the LSB on the final rising edge of the half-period.
- R5: With `fmt_sel` = 2'b11 (right-justified, short word), `lrck` high marks the left channel. The sample is the last 16 bits before the `lrck` transition. It is output in bits 23:8, and bits 7:0 read zero.
- R6: In I2S and left-justified modes, bit slots beyond the 24th data bit of a half-period do not change the sample.
- R7: In I2S and left-justified modes, a half-period that carries fewer than 24 data bits yields a sample whose missing low bits are zero.
- R8: `smp_valid` is high for exactly one clock cycle per stereo frame. It rises after the right channel's half-period has ended. In that cycle, `left_smp` and `right_smp` hold the left and right samples of that same frame.
- R9: A half-period already in progress when reset is released is never reported. The first strobe needs one complete left half-period followed by one complete right half-period.
- R10: The number of `sclk` cycles per half-period may differ from frame to frame without any reconfiguration, and every format still places its bits as stated above.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must run several times faster than `sclk` |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Framing select: 00 I2S, 01 left-justified, 10 right-justified 24-bit, 11 right-justified 16-bit |
| sclk | input | 1 | Serial bit clock; data is taken on its rising edge |
| lrck | input | 1 | Frame clock; each level is one channel's half-period |
| sdin | input | 1 | Serial data, MSB first |
| left_smp | output | 24 | Last completed left sample, MSB aligned |
| right_smp | output | 24 | Last completed right sample, MSB aligned |
| smp_valid | output | 1 | One-cycle strobe: a left/right pair is ready |

## Verification
Each format is driven with half-periods that are longer than the word, exactly as long as the word, and shorter than the word. In the justified-left modes, ones are sent after the word, so a receiver that lets trailing slots leak into the sample is told apart from one that ignores them. In the right-justified modes, the same ones are sent ahead of the word, which tells taking the last bits apart from taking the first ones. The phase length is changed between frames inside a run, so anything that assumes a fixed frame geometry shows up as a misplaced word. Every run begins with a partial half-period right after reset, which exposes any receiver that reports an incomplete channel.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

   typedef enum logic [1:0] {
      FMT_I2S      = 2'b00,
      FMT_LJ       = 2'b01,
      FMT_RJ_WIDE  = 2'b10,
      FMT_RJ_SHORT = 2'b11
   } rx_fmt_e;

   // Frame-clock level that marks the left channel in a given framing
   function automatic logic left_level(rx_fmt_e f);
      return (f == FMT_I2S) ? 1'b0 : 1'b1;
   endfunction

endpackage

// File: rtl/sarx_in_sync.sv
module sarx_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic lrck_i,
   input  logic sdin_i,
   output logic tick_o,
   output logic lr_o,
   output logic bit_o
);

   logic [STAGES-1:0] sclk_sr;
   logic [STAGES-1:0] lr_sr;
   logic [STAGES-1:0] din_sr;
   logic              sclk_last;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sclk_sr   <= '0;
         lr_sr     <= '0;
         din_sr    <= '0;
         sclk_last <= 1'b0;
      end else begin
         sclk_sr   <= {sclk_sr[STAGES-2:0], sclk_i};
         lr_sr     <= {lr_sr[STAGES-2:0], lrck_i};
         din_sr    <= {din_sr[STAGES-2:0], sdin_i};
         sclk_last <= sclk_sr[STAGES-1];
      end
   end

   // All three wires share the same delay, so the data and the frame level
   // seen at a tick are the values present at that bit-clock rising edge.
   assign tick_o = sclk_sr[STAGES-1] & ~sclk_last;
   assign lr_o   = lr_sr[STAGES-1];
   assign bit_o  = din_sr[STAGES-1];

   // R10: bit slots are isolated events, never two in back-to-back cycles
   assert_tick_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o);

endmodule

// File: rtl/sarx_word_asm.sv
module sarx_word_asm
   import serial_audio_rx_pkg::*;
#(
   parameter int WORD_W       = 24,
   parameter int SHORT_W      = 16,
   parameter bit SHORT_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  rx_fmt_e           fmt_i,
   input  logic              tick_i,
   input  logic              lr_i,
   input  logic              din_i,
   output logic              done_o,
   output logic              done_left_o,
   output logic [WORD_W-1:0] done_word_o
);

   localparam int                CNT_W   = $clog2(WORD_W + 1);
   localparam int                PAD_W   = WORD_W - SHORT_W;
   localparam logic [CNT_W-1:0]  CNT_MAX = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0]  TOP_POS = CNT_W'(WORD_W - 1);

   logic              is_i2s;
   logic              lr_d1, lr_d2;
   logic [1:0]        hist;
   logic              hist_ok;
   logic              eff_now, eff_prev;
   logic              edge_w;
   logic              phase_full;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  pos;
   logic [WORD_W-1:0] lj_word;
   logic [WORD_W-1:0] rj_sr;
   logic [WORD_W-1:0] short_word;

   assign is_i2s = (fmt_i == FMT_I2S);

   // I2S is handled as left-justified framing on a frame clock delayed by
   // one bit slot: the level at the previous slot owns the current bit.
   assign eff_now  = is_i2s ? lr_d1 : lr_i;
   assign eff_prev = is_i2s ? lr_d2 : lr_d1;
   assign hist_ok  = is_i2s ? (hist == 2'd2) : (hist != 2'd0);
   assign edge_w   = tick_i && hist_ok && (eff_now != eff_prev);
   assign pos      = TOP_POS - cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lr_d1      <= 1'b0;
         lr_d2      <= 1'b0;
         hist       <= 2'd0;
         phase_full <= 1'b0;
         cnt        <= '0;
         lj_word    <= '0;
         rj_sr      <= '0;
      end else if (tick_i) begin
         lr_d1 <= lr_i;
         lr_d2 <= lr_d1;
         if (hist != 2'd2) hist <= hist + 2'd1;
         rj_sr <= {rj_sr[WORD_W-2:0], din_i};
         if (edge_w) begin
            lj_word    <= {din_i, {(WORD_W-1){1'b0}}};
            cnt        <= CNT_W'(1);
            phase_full <= 1'b1;
         end else if (cnt < CNT_MAX) begin
            lj_word[pos] <= din_i;
            cnt          <= cnt + 1'b1;
         end
      end
   end

   generate
      if (SHORT_SIGNED) begin : g_short_sext
         assign short_word = {{PAD_W{rj_sr[SHORT_W-1]}}, rj_sr[SHORT_W-1:0]};
      end else begin : g_short_left
         assign short_word = {rj_sr[SHORT_W-1:0], {PAD_W{1'b0}}};
      end
   endgenerate

   always_comb begin
      unique case (fmt_i)
         FMT_RJ_WIDE:  done_word_o = rj_sr;
         FMT_RJ_SHORT: done_word_o = short_word;
         default:      done_word_o = lj_word;
      endcase
   end

   assign done_o      = edge_w && phase_full;
   assign done_left_o = (eff_prev == left_level(fmt_i));

   // R6: the slot counter saturates at the word width
   assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_MAX);

   // R9: no word is reported before a whole half-period was observed
   assert_first_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> $past(hist != 2'd0));

endmodule

// File: rtl/sarx_frame_out.sv
module sarx_frame_out #(
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_i,
   input  logic              done_left_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [WORD_W-1:0] left_o,
   output logic [WORD_W-1:0] right_o,
   output logic              valid_o
);

   logic have_left;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         left_o    <= '0;
         right_o   <= '0;
         valid_o   <= 1'b0;
         have_left <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (done_i) begin
            if (done_left_i) begin
               left_o    <= word_i;
               have_left <= 1'b1;
            end else begin
               right_o <= word_i;
               if (have_left) begin
                  valid_o   <= 1'b1;
                  have_left <= 1'b0;
               end
            end
         end
      end
   end

   // R8: the strobe lasts a single cycle
   assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   // R8: the strobe follows the close of a right half-period
   assert_valid_after_right_R8: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(done_i && !done_left_i));

   // R8: the left sample holds unless a left half-period just closed
   assert_left_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(done_i && done_left_i)) |-> $stable(left_o));

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
   import serial_audio_rx_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int WORD_W       = 24,
   parameter int SHORT_W      = 16,
   parameter bit SHORT_SIGNED = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        fmt_sel,
   input  logic              sclk,
   input  logic              lrck,
   input  logic              sdin,
   output logic [WORD_W-1:0] left_smp,
   output logic [WORD_W-1:0] right_smp,
   output logic              smp_valid
);

   localparam int PAD_W = WORD_W - SHORT_W;

   initial begin
      assert (SYNC_STAGES >= 2)
         else $error("SYNC_STAGES must be at least 2");
      assert (SHORT_W >= 1 && SHORT_W < WORD_W)
         else $error("SHORT_W must be positive and below WORD_W");
   end

   rx_fmt_e           fmt_e;
   logic              tick;
   logic              lr_s;
   logic              din_s;
   logic              done;
   logic              done_left;
   logic [WORD_W-1:0] done_word;

   assign fmt_e = rx_fmt_e'(fmt_sel);

   sarx_in_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .sclk_i (sclk),
      .lrck_i (lrck),
      .sdin_i (sdin),
      .tick_o (tick),
      .lr_o   (lr_s),
      .bit_o  (din_s)
   );

   sarx_word_asm #(
      .WORD_W       (WORD_W),
      .SHORT_W      (SHORT_W),
      .SHORT_SIGNED (SHORT_SIGNED)
   ) u_asm (
      .clk         (clk),
      .rst_n       (rst_n),
      .fmt_i       (fmt_e),
      .tick_i      (tick),
      .lr_i        (lr_s),
      .din_i       (din_s),
      .done_o      (done),
      .done_left_o (done_left),
      .done_word_o (done_word)
   );

   sarx_frame_out #(
      .WORD_W (WORD_W)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .done_i      (done),
      .done_left_i (done_left),
      .word_i      (done_word),
      .left_o      (left_smp),
      .right_o     (right_smp),
      .valid_o     (smp_valid)
   );

   // R1: outputs leave reset cleared
   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (smp_valid == 1'b0 && left_smp == '0 && right_smp == '0));

   generate
      if (!SHORT_SIGNED) begin : g_short_chk
         // R5: short right-justified words arrive with clear low bits
         assert_short_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (smp_valid && fmt_e == FMT_RJ_SHORT) |-> right_smp[PAD_W-1:0] == '0);
      end
   endgenerate

endmodule

// File: tb/serial_audio_rx_tb.sv
module serial_audio_rx_tb;

   localparam int HALF = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  fmt = 2'b00;
   logic        sclk = 1'b0;
   logic        lrck = 1'b0;
   logic        sdin = 1'b0;
   logic [23:0] left_smp, right_smp;
   logic        smp_valid;

   always #4 clk = ~clk;

   serial_audio_rx u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .fmt_sel   (fmt),
      .sclk      (sclk),
      .lrck      (lrck),
      .sdin      (sdin),
      .left_smp  (left_smp),
      .right_smp (right_smp),
      .smp_valid (smp_valid)
   );

   int          checks = 0;
   int          fails = 0;
   int          valids_seen = 0;
   int          cyc = 0;
   bit          finished = 1'b0;
   bit          prev_v = 1'b0;
   logic [23:0] exp_l[$];
   logic [23:0] exp_r[$];
   string       exp_tag[$];

   task automatic chk(bit ok, string tag, string what, logic [47:0] act, logic [47:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic left_lv(logic [1:0] f);
      return (f != 2'b00);
   endfunction

   function automatic logic [23:0] val(int s);
      logic [31:0] t;
      t = (s * 32'h9E3779B1) ^ (s << 5) ^ 32'h00A5C3;
      return t[23:0];
   endfunction

   function automatic logic ser_bit(logic [1:0] f, int n, int i, logic [23:0] v);
      int w;
      w = (f == 2'b11) ? 16 : 24;
      if (f < 2'b10) return (i < 24) ? v[23-i] : 1'b1;
      if (i < n - w) return 1'b1;
      return v[w-1-(i-(n-w))];
   endfunction

   function automatic logic [23:0] exp_word(logic [1:0] f, int n, logic [23:0] v);
      logic [23:0] m;
      if (f == 2'b10) return v;
      if (f == 2'b11) return {v[15:0], 8'h00};
      if (n >= 24) return v;
      m = 24'hFFFFFF << (24 - n);
      return v & m;
   endfunction

   task automatic slot(logic lv, logic b);
      sclk = 1'b0;
      lrck = lv;
      sdin = b;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
   endtask

   // driver: pushes the expected pair, then serializes one frame
   task automatic send_frame(int n, logic [23:0] l, logic [23:0] r, string tag);
      logic lv;
      lv = left_lv(fmt);
      exp_l.push_back(exp_word(fmt, n, l));
      exp_r.push_back(exp_word(fmt, n, r));
      exp_tag.push_back(tag);
      for (int k = 0; k < 2 * n; k++) begin
         logic eff, eff_next, b;
         eff      = (k < n) ? lv : !lv;
         eff_next = (k + 1 < n) ? lv : ((k + 1 < 2 * n) ? !lv : lv);
         b        = (k < n) ? ser_bit(fmt, n, k, l) : ser_bit(fmt, n, k - n, r);
         slot((fmt == 2'b00) ? eff_next : eff, b);
      end
   endtask

   task automatic start(logic [1:0] f);
      rst_n = 1'b0;
      fmt   = f;
      sclk  = 1'b0;
      lrck  = 1'b0;
      sdin  = 1'b0;
      repeat (5) @(negedge clk);
      chk(left_smp == 24'h0 && right_smp == 24'h0, "R1", "samples in reset",
          {left_smp, right_smp}, 48'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(smp_valid == 1'b0 && left_smp == 24'h0 && right_smp == 24'h0, "R1",
          "state after reset", {23'h0, smp_valid, left_smp}, 48'h0);
      valids_seen = 0;
      // partial right half-period in progress at reset release (R9)
      for (int j = 0; j < 5; j++)
         slot((f == 2'b00 && j == 4) ? left_lv(f) : !left_lv(f), 1'b1);
   endtask

   task automatic finish_run(int nframes, string tag);
      for (int j = 0; j < 3; j++) slot(left_lv(fmt), 1'b0);
      repeat (10) @(negedge clk);
      chk(valids_seen == nframes, "R9", {tag, " strobe count"}, 48'(valids_seen), 48'(nframes));
      chk(exp_l.size() == 0, "R8", {tag, " pending pairs"}, 48'(exp_l.size()), 48'h0);
   endtask

   // monitor: pops and compares on every strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (smp_valid) begin
            chk(!prev_v, "R8", "strobe width", 48'h2, 48'h1);
            valids_seen++;
            if (exp_l.size() == 0) begin
               chk(1'b0, "R9", "unexpected strobe", {left_smp, right_smp}, 48'h0);
            end else begin
               logic [23:0] el, er;
               string       tg;
               el = exp_l.pop_front();
               er = exp_r.pop_front();
               tg = exp_tag.pop_front();
               chk(left_smp == el, tg, "left sample", {24'h0, left_smp}, {24'h0, el});
               chk(right_smp == er, tg, "right sample", {24'h0, right_smp}, {24'h0, er});
            end
         end
         prev_v = smp_valid;
      end else begin
         prev_v = 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc == 150000 && !finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL R10 watchdog expired actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      // I2S: R2, R6, R7, R10
      start(2'b00);
      send_frame(32, val(1), val(2), "R2 R6");
      send_frame(32, val(3), val(4), "R2 R6");
      send_frame(24, val(5), val(6), "R2");
      send_frame(20, val(7), val(8), "R7");
      send_frame(28, val(9), val(10), "R10");
      finish_run(5, "i2s");

      // left-justified: R3, R6, R7, R10
      start(2'b01);
      send_frame(32, val(11), val(12), "R3 R6");
      send_frame(24, val(13), val(14), "R3");
      send_frame(18, val(15), val(16), "R7");
      send_frame(30, val(17), val(18), "R10");
      finish_run(4, "lj");

      // right-justified full word: R4, R10
      start(2'b10);
      send_frame(32, val(19), val(20), "R4");
      send_frame(24, val(21), val(22), "R4");
      send_frame(26, val(23), val(24), "R4 R10");
      finish_run(3, "rj24");

      // right-justified short word: R5, R10
      start(2'b11);
      send_frame(32, val(25), val(26), "R5");
      send_frame(16, val(27), val(28), "R5");
      send_frame(20, val(29), val(30), "R5 R10");
      finish_run(3, "rj16");

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule